// File: doc/BRIEF.md
# Single-Clock User Request Front-End for a Burst SRAM Controller

This block sits between user logic and the command sequencer of a burst SRAM controller, on one clock. User logic posts writes (address plus a high and a low data word per beat) and reads (address) with active-low enables on the rising edge. The block holds the accepted requests in two separate queues that the sequencer drains. It reports a full flag for each queue and passes a user-forced no-operation request on to the sequencer.

Read data comes back from the sequencer as beats with per-word error flags. The block holds these beats in a return buffer and releases them to the user at a fixed latency counted from the edge on which the read was accepted, so user logic never waits on a handshake. With the default burst of four, a write takes two cycles of data and is stored as one four-word queue entry. Each read returns two beats on consecutive cycles.

Top module: `qf_req_frontend`

## Requirements
- R1: While reset is asserted and after it, until the first request, `wr_full`, `rd_full`, `wq_valid`, `rq_valid`, `rd_valid` and `seq_nop` are all low.
- R2: A write starts only on an edge where `wr_addr_en_n` and `wr_data_en_n` are both low. An edge with just one of them low leaves the write queue unchanged.
- R3: In burst-4 mode the high and low words on the request edge are beat 0. The words on the next edge are beat 1 and are taken whatever the enables are. Enables low on that second edge do not start a new write. The entry appears on the write queue only after the second edge, with `wq_data` = {hi0, lo0, hi1, lo1} (hi0 in the most significant bits).
- R4: A read is accepted on an edge where `rd_en_n` is low. In burst-4 mode a read on the edge right after an accepted read is ignored.
- R5: `wr_full` / `rd_full` are high exactly when the queue holds its depth of entries (4 by default). A write or read request made while its flag is high is dropped and never reaches the queue.
- R6: Each queue presents its entries to the sequencer in acceptance order, one entry removed per cycle that its pop input is high.
- R7: For a read accepted on edge N, `rd_valid` is high after edge N+16 and, in burst-4 mode, also after edge N+17. `rd_valid` is low in every cycle that carries no read beat.
- R8: Each returned beat appears on `rd_hi`/`rd_lo` with its own flags, `rd_err_hi` belonging to the high word and `rd_err_lo` to the low word, in the order the beats were returned.
- R9: While `cal_done` is low, no write or read request is accepted.
- R10: `seq_nop` equals `nop_req` delayed by one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all logic |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cal_done | input | 1 | Requests are honoured only while high |
| wr_addr_en_n | input | 1 | Active-low write address enable |
| wr_data_en_n | input | 1 | Active-low write data enable |
| wr_addr | input | AW | Write address, sampled with the enables |
| wr_hi | input | DW | High write data word of the current beat |
| wr_lo | input | DW | Low write data word of the current beat |
| wr_full | output | 1 | Write queue full |
| rd_en_n | input | 1 | Active-low read request |
| rd_addr | input | AW | Read address |
| rd_full | output | 1 | Read queue full |
| rd_valid | output | 1 | A read beat is on the read data outputs |
| rd_hi | output | DW | High read word |
| rd_lo | output | DW | Low read word |
| rd_err_hi | output | 1 | Error flag of the high read word |
| rd_err_lo | output | 1 | Error flag of the low read word |
| nop_req | input | 1 | User-forced no-operation request |
| seq_nop | output | 1 | No-operation request towards the sequencer |
| wq_valid | output | 1 | Write queue head is valid |
| wq_addr | output | AW | Address of the write queue head |
| wq_data | output | BURST*DW | Data of the write queue head |
| wq_pop | input | 1 | Sequencer takes the write queue head |
| rq_valid | output | 1 | Read queue head is valid |
| rq_addr | output | AW | Address of the read queue head |
| rq_pop | input | 1 | Sequencer takes the read queue head |
| ret_valid | input | 1 | Sequencer delivers a read beat |
| ret_hi | input | DW | Returned high word |
| ret_lo | input | DW | Returned low word |
| ret_err_hi | input | 1 | Error flag of the returned high word |
| ret_err_lo | input | 1 | Error flag of the returned low word |

## Verification
On every cycle, the embedded properties check several rules. No queue is pushed while full or popped while empty. A burst-4 write commits only on the edge after a request with both enables low. A read beat pair never opens with a single beat. The release slot never finds the return buffer empty. The bench's scenarios are needed for the rest. These are the exact 16- and 17-cycle release points, the order and word layout of queue entries, and the dropping of requests made while full, before calibration or with mismatched enables. The same holds for the suppression of a request made in a write's data cycle or right after a read.

// File: rtl/qf_pkg.sv
package qf_pkg;
  typedef enum logic {
    CAP_IDLE = 1'b0,
    CAP_DATA = 1'b1
  } cap_state_e;
endpackage

// File: rtl/qf_fifo.sv
module qf_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int PW = $clog2(DEPTH);

  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [PW:0]   cnt_q, cnt_d;

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (push) wp_d = wp_q + 1'b1;
    if (pop)  rp_d = rp_q + 1'b1;
    if (push && !pop) cnt_d = cnt_q + 1'b1;
    else if (pop && !push) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem_q[wp_q] <= din;
  end

  assign dout  = mem_q[rp_q];
  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == (PW+1)'(DEPTH));

  // R5: a full queue is never written
  a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  // R6: an empty queue is never read
  a_r6_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/qf_wr_capture.sv
module qf_wr_capture
  import qf_pkg::*;
#(
  parameter int AW    = 20,
  parameter int DW    = 18,
  parameter int BURST = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cal_done,
  input  logic                   q_full,
  input  logic                   addr_en_n,
  input  logic                   data_en_n,
  input  logic [AW-1:0]          addr,
  input  logic [DW-1:0]          hi,
  input  logic [DW-1:0]          lo,
  output logic                   push,
  output logic [AW+BURST*DW-1:0] entry
);
  logic req_ok;
  assign req_ok = !addr_en_n && !data_en_n && cal_done && !q_full;

  generate
    if (BURST == 4) begin : g_b4
      cap_state_e    st_q, st_d;
      logic          start;
      logic [AW-1:0] a_q;
      logic [DW-1:0] h_q, l_q;

      always_comb begin
        start = (st_q == CAP_IDLE) && req_ok;
        st_d  = st_q;
        case (st_q)
          CAP_IDLE: if (start) st_d = CAP_DATA;
          CAP_DATA: st_d = CAP_IDLE;
          default:  st_d = CAP_IDLE;
        endcase
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= CAP_IDLE;
        else        st_q <= st_d;
      end

      always_ff @(posedge clk) begin
        if (start) begin
          a_q <= addr;
          h_q <= hi;
          l_q <= lo;
        end
      end

      assign push  = (st_q == CAP_DATA);
      assign entry = {a_q, h_q, l_q, hi, lo};

      // R3: a commit follows an edge with both write enables low
      a_r3_commit_after_request: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> $past(!addr_en_n && !data_en_n && cal_done));
    end else begin : g_b2
      assign push  = req_ok;
      assign entry = {addr, hi, lo};
    end
  endgenerate
endmodule

// File: rtl/qf_rd_align.sv
module qf_rd_align #(
  parameter int DW    = 18,
  parameter int LAT   = 16,
  parameter int BURST = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rd_acc,
  input  logic            ret_empty,
  input  logic [2*DW+1:0] ret_word,
  output logic            ret_pop,
  output logic            rd_valid,
  output logic [DW-1:0]   rd_hi,
  output logic [DW-1:0]   rd_lo,
  output logic            rd_err_hi,
  output logic            rd_err_lo
);
  logic [LAT-1:0]  tm_q, tm_d;
  logic            slot;
  logic            val_q;
  logic [2*DW+1:0] word_q;

  assign tm_d = {tm_q[LAT-2:0], rd_acc};

  generate
    if (BURST == 4) begin : g_b4
      logic sec_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sec_q <= 1'b0;
        else        sec_q <= tm_q[LAT-1];
      end
      assign slot = tm_q[LAT-1] | sec_q;

      // R7: beats of one read come as a pair
      a_r7_beat_pair: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_valid) |=> rd_valid);
    end else begin : g_b2
      assign slot = tm_q[LAT-1];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tm_q  <= '0;
      val_q <= 1'b0;
    end else begin
      tm_q  <= tm_d;
      val_q <= slot;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    word_q <= '0;
    else if (slot) word_q <= ret_word;
  end

  assign ret_pop   = slot;
  assign rd_valid  = val_q;
  assign rd_err_hi = word_q[2*DW+1];
  assign rd_err_lo = word_q[2*DW];
  assign rd_hi     = word_q[2*DW-1:DW];
  assign rd_lo     = word_q[DW-1:0];

  // R8: a release slot always finds a returned beat waiting
  a_r8_ret_ready: assert property (@(posedge clk) disable iff (!rst_n)
    ret_pop |-> !ret_empty);
endmodule

// File: rtl/qf_req_frontend.sv
module qf_req_frontend #(
  parameter int AW        = 20,
  parameter int DW        = 18,
  parameter int BURST     = 4,
  parameter int WQ_DEPTH  = 4,
  parameter int RQ_DEPTH  = 4,
  parameter int RET_DEPTH = 16,
  parameter int RD_LAT    = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cal_done,
  input  logic                wr_addr_en_n,
  input  logic                wr_data_en_n,
  input  logic [AW-1:0]       wr_addr,
  input  logic [DW-1:0]       wr_hi,
  input  logic [DW-1:0]       wr_lo,
  output logic                wr_full,
  input  logic                rd_en_n,
  input  logic [AW-1:0]       rd_addr,
  output logic                rd_full,
  output logic                rd_valid,
  output logic [DW-1:0]       rd_hi,
  output logic [DW-1:0]       rd_lo,
  output logic                rd_err_hi,
  output logic                rd_err_lo,
  input  logic                nop_req,
  output logic                seq_nop,
  output logic                wq_valid,
  output logic [AW-1:0]       wq_addr,
  output logic [BURST*DW-1:0] wq_data,
  input  logic                wq_pop,
  output logic                rq_valid,
  output logic [AW-1:0]       rq_addr,
  input  logic                rq_pop,
  input  logic                ret_valid,
  input  logic [DW-1:0]       ret_hi,
  input  logic [DW-1:0]       ret_lo,
  input  logic                ret_err_hi,
  input  logic                ret_err_lo
);
  localparam int EW = AW + BURST*DW;
  localparam int RW = 2*DW + 2;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rs_q;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i_n = rs_q[1];

  // write path
  logic          wq_push, wq_empty, wq_full;
  logic [EW-1:0] wq_entry, wq_dout;

  qf_wr_capture #(.AW(AW), .DW(DW), .BURST(BURST)) u_cap (
    .clk(clk), .rst_n(rst_i_n), .cal_done(cal_done), .q_full(wq_full),
    .addr_en_n(wr_addr_en_n), .data_en_n(wr_data_en_n),
    .addr(wr_addr), .hi(wr_hi), .lo(wr_lo),
    .push(wq_push), .entry(wq_entry)
  );

  qf_fifo #(.W(EW), .DEPTH(WQ_DEPTH)) u_wq (
    .clk(clk), .rst_n(rst_i_n), .push(wq_push), .din(wq_entry),
    .pop(wq_pop), .dout(wq_dout), .empty(wq_empty), .full(wq_full)
  );

  assign wr_full  = wq_full;
  assign wq_valid = !wq_empty;
  assign wq_addr  = wq_dout[EW-1 -: AW];
  assign wq_data  = wq_dout[BURST*DW-1:0];

  // read path
  logic          rd_acc, racc_q, rq_empty, rq_full;
  assign rd_acc = !rd_en_n && cal_done && !rq_full && !((BURST == 4) && racc_q);

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) racc_q <= 1'b0;
    else          racc_q <= rd_acc;
  end

  qf_fifo #(.W(AW), .DEPTH(RQ_DEPTH)) u_rq (
    .clk(clk), .rst_n(rst_i_n), .push(rd_acc), .din(rd_addr),
    .pop(rq_pop), .dout(rq_addr), .empty(rq_empty), .full(rq_full)
  );

  assign rd_full  = rq_full;
  assign rq_valid = !rq_empty;

  // read return buffer and fixed-latency release
  logic          ret_pop, ret_empty, ret_full;
  logic [RW-1:0] ret_word;

  qf_fifo #(.W(RW), .DEPTH(RET_DEPTH)) u_ret (
    .clk(clk), .rst_n(rst_i_n), .push(ret_valid),
    .din({ret_err_hi, ret_err_lo, ret_hi, ret_lo}),
    .pop(ret_pop), .dout(ret_word), .empty(ret_empty), .full(ret_full)
  );

  qf_rd_align #(.DW(DW), .LAT(RD_LAT), .BURST(BURST)) u_align (
    .clk(clk), .rst_n(rst_i_n), .rd_acc(rd_acc), .ret_empty(ret_empty),
    .ret_word(ret_word), .ret_pop(ret_pop), .rd_valid(rd_valid),
    .rd_hi(rd_hi), .rd_lo(rd_lo), .rd_err_hi(rd_err_hi), .rd_err_lo(rd_err_lo)
  );

  // no-operation request towards the sequencer
  logic nop_q;
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) nop_q <= 1'b0;
    else          nop_q <= nop_req;
  end
  assign seq_nop = nop_q;

  // R8: returned beats are never dropped for lack of room
  a_r8_ret_no_drop: assert property (@(posedge clk) disable iff (!rst_i_n)
    ret_valid |-> !ret_full);
endmodule

// File: tb/tb_qf_req_frontend.sv
module tb_qf_req_frontend;
  localparam int AW = 20;
  localparam int DW = 18;
  localparam int BURST = 4;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, cal_done, wr_addr_en_n, wr_data_en_n, rd_en_n, nop_req;
  logic [AW-1:0] wr_addr, rd_addr, wq_addr, rq_addr;
  logic [DW-1:0] wr_hi, wr_lo, rd_hi, rd_lo, ret_hi, ret_lo;
  logic wr_full, rd_full, rd_valid, rd_err_hi, rd_err_lo, seq_nop;
  logic wq_valid, wq_pop, rq_valid, rq_pop, ret_valid, ret_err_hi, ret_err_lo;
  logic [BURST*DW-1:0] wq_data;

  qf_req_frontend dut (
    .clk(clk), .rst_n(rst_n), .cal_done(cal_done),
    .wr_addr_en_n(wr_addr_en_n), .wr_data_en_n(wr_data_en_n), .wr_addr(wr_addr),
    .wr_hi(wr_hi), .wr_lo(wr_lo), .wr_full(wr_full),
    .rd_en_n(rd_en_n), .rd_addr(rd_addr), .rd_full(rd_full),
    .rd_valid(rd_valid), .rd_hi(rd_hi), .rd_lo(rd_lo),
    .rd_err_hi(rd_err_hi), .rd_err_lo(rd_err_lo),
    .nop_req(nop_req), .seq_nop(seq_nop),
    .wq_valid(wq_valid), .wq_addr(wq_addr), .wq_data(wq_data), .wq_pop(wq_pop),
    .rq_valid(rq_valid), .rq_addr(rq_addr), .rq_pop(rq_pop),
    .ret_valid(ret_valid), .ret_hi(ret_hi), .ret_lo(ret_lo),
    .ret_err_hi(ret_err_hi), .ret_err_lo(ret_err_lo)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 1'b0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] f_hi(input logic [AW-1:0] a, input bit b);
    return DW'(32'(a) * 5 + (b ? 7 : 0) + 3);
  endfunction
  function automatic logic [DW-1:0] f_lo(input logic [AW-1:0] a, input bit b);
    return DW'(32'(a) + 1000 + (b ? 11 : 0));
  endfunction

  // bench models
  logic [AW+4*DW-1:0] ew [0:63];
  int ew_h = 0, ew_t = 0;
  logic [AW-1:0] er_a [0:255];
  int er_due [0:255];
  int er_h = 0, er_t = 0;
  logic [AW-1:0] rl [0:255];
  int rl_h = 0, rl_t = 0;
  bit rl_beat = 1'b0;
  bit b_pend = 1'b0, prev_racc = 1'b0, last_nop = 1'b0;
  logic [AW-1:0] p_addr;
  logic [DW-1:0] p_h0, p_l0;
  bit seq_wr_en = 1'b0, seq_rd_en = 1'b0;

  // sequencer model and read output checker
  always @(negedge clk) begin
    if (!rst_n) begin
      wq_pop = 1'b0; rq_pop = 1'b0; ret_valid = 1'b0;
      ret_hi = '0; ret_lo = '0; ret_err_hi = 1'b0; ret_err_lo = 1'b0;
    end else begin
      // R6: write queue order and R3 entry layout
      if (seq_wr_en && wq_valid) begin
        chk(ew_h < ew_t && {wq_addr, wq_data} == ew[ew_h], "R6", "write entry",
            {wq_addr, wq_data}, ew[ew_h]);
        if (ew_h < ew_t) ew_h++;
        wq_pop = 1'b1;
      end else wq_pop = 1'b0;
      // return beats for popped reads
      ret_valid = 1'b0;
      if (rl_h != rl_t) begin
        ret_valid  = 1'b1;
        ret_hi     = f_hi(rl[rl_h], rl_beat);
        ret_lo     = f_lo(rl[rl_h], rl_beat);
        ret_err_hi = rl[rl_h][0] ^ rl_beat;
        ret_err_lo = rl[rl_h][1];
        if (rl_beat) rl_h++;
        rl_beat = ~rl_beat;
      end
      if (seq_rd_en && rq_valid) begin
        rl[rl_t] = rq_addr; rl_t++;
        rq_pop = 1'b1;
      end else rq_pop = 1'b0;
      // R7 / R8: read data release
      if (er_h < er_t && (cyc == er_due[er_h] || cyc == er_due[er_h] + 1)) begin
        bit b;
        b = (cyc == er_due[er_h] + 1);
        chk(rd_valid == 1'b1, "R7", "rd_valid at release", rd_valid, 1);
        chk({rd_err_hi, rd_err_lo, rd_hi, rd_lo} ==
            {er_a[er_h][0] ^ b, er_a[er_h][1], f_hi(er_a[er_h], b), f_lo(er_a[er_h], b)},
            "R8", "read beat", {rd_err_hi, rd_err_lo, rd_hi, rd_lo},
            {er_a[er_h][0] ^ b, er_a[er_h][1], f_hi(er_a[er_h], b), f_lo(er_a[er_h], b)});
        if (b) er_h++;
      end else begin
        // R4 / R7: no beat expected, so no valid
        chk(rd_valid == 1'b0, "R4", "unexpected rd_valid", rd_valid, 0);
      end
    end
  end

  // one cycle of stimulus: drive now, return at the next falling edge
  task automatic step(input bit wa_n, input bit wd_n, input logic [AW-1:0] wa,
                      input logic [DW-1:0] h, input logic [DW-1:0] l,
                      input bit r_n, input logic [AW-1:0] ra, input bit nop);
    chk(seq_nop == last_nop, "R10", "seq_nop", seq_nop, last_nop);
    wr_addr_en_n = wa_n; wr_data_en_n = wd_n; wr_addr = wa; wr_hi = h; wr_lo = l;
    rd_en_n = r_n; rd_addr = ra; nop_req = nop;
    if (b_pend) begin
      ew[ew_t] = {p_addr, p_h0, p_l0, h, l}; ew_t++;
      b_pend = 1'b0;
    end else if (!wa_n && !wd_n && cal_done && !wr_full) begin
      b_pend = 1'b1; p_addr = wa; p_h0 = h; p_l0 = l;
    end
    if (!r_n && cal_done && !rd_full && !prev_racc) begin
      er_a[er_t] = ra; er_due[er_t] = cyc + 17; er_t++;
      prev_racc = 1'b1;
    end else prev_racc = 1'b0;
    last_nop = nop;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) step(1, 1, '0, '0, '0, 1, '0, 0);
  endtask

  initial begin
    rst_n = 1'b0; cal_done = 1'b0;
    wr_addr_en_n = 1'b1; wr_data_en_n = 1'b1; wr_addr = '0; wr_hi = '0; wr_lo = '0;
    rd_en_n = 1'b1; rd_addr = '0; nop_req = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(wr_full == 0, "R1", "wr_full", wr_full, 0);
    chk(rd_full == 0, "R1", "rd_full", rd_full, 0);
    chk(wq_valid == 0, "R1", "wq_valid", wq_valid, 0);
    chk(rq_valid == 0, "R1", "rq_valid", rq_valid, 0);
    chk(rd_valid == 0, "R1", "rd_valid", rd_valid, 0);
    chk(seq_nop == 0, "R1", "seq_nop", seq_nop, 0);
    rst_n = 1'b1;
    idle(4);
    chk(wq_valid == 0 && rq_valid == 0, "R1", "queues after reset", {wq_valid, rq_valid}, 0);

    // R9: requests before calibration are dropped
    step(0, 0, 20'h11, 18'h1, 18'h2, 0, 20'h22, 0);
    step(1, 1, '0, 18'h3, 18'h4, 0, 20'h23, 0);
    idle(2);
    chk(wq_valid == 0, "R9", "write before cal_done", wq_valid, 0);
    chk(rq_valid == 0, "R9", "read before cal_done", rq_valid, 0);
    cal_done = 1'b1;

    // R2: mismatched enables
    step(0, 1, 20'h31, 18'h5, 18'h6, 1, '0, 1);
    step(1, 0, 20'h32, 18'h7, 18'h8, 1, '0, 0);
    idle(3);
    chk(wq_valid == 0, "R2", "single enable low", wq_valid, 0);

    // R3: commit only after the second data edge
    step(0, 0, 20'h41, 18'h101, 18'h102, 1, '0, 1);
    chk(wq_valid == 0, "R3", "entry after request edge", wq_valid, 0);
    step(1, 1, '0, 18'h103, 18'h104, 1, '0, 0);
    chk(wq_valid == 1, "R3", "entry after data edge", wq_valid, 1);
    seq_wr_en = 1'b1;
    idle(3);
    chk(wq_valid == 0, "R6", "queue drained", wq_valid, 0);

    // R5: fill the write queue; second data cycle of write 1 carries enables low
    seq_wr_en = 1'b0;
    for (int i = 0; i < 5; i++) begin
      if (i == 4) chk(wr_full == 1, "R5", "wr_full at depth", wr_full, 1);
      step(0, 0, AW'(32'h100 + i), DW'(i * 4 + 1), DW'(i * 4 + 2), 1, '0, i[0]);
      step(i != 1, i != 1, AW'(32'h1F0 + i), DW'(i * 4 + 3), DW'(i * 4 + 4), 1, '0, 0);
    end
    chk(wr_full == 1, "R5", "wr_full held", wr_full, 1);
    seq_wr_en = 1'b1;
    idle(8);
    chk(wq_valid == 0 && wr_full == 0, "R5", "only four entries stored",
        {wq_valid, wr_full}, 0);
    chk(ew_h == ew_t, "R3", "all expected writes seen", ew_h, ew_t);

    // R4 / R7: reads on every cycle, only alternate ones accepted
    seq_rd_en = 1'b1;
    for (int i = 0; i < 12; i++) step(1, 1, '0, '0, '0, 0, AW'(32'h200 + i * 3), i[1]);
    idle(22);

    // R5: fill the read queue
    seq_rd_en = 1'b0;
    for (int i = 0; i < 5; i++) begin
      if (i == 4) chk(rd_full == 1, "R5", "rd_full at depth", rd_full, 1);
      step(1, 1, '0, '0, '0, 0, AW'(32'h300 + i), 0);
      idle(1);
    end
    seq_rd_en = 1'b1;
    idle(26);
    chk(rd_full == 0 && rq_valid == 0, "R5", "read queue drained", {rd_full, rq_valid}, 0);

    // mixed sweep of writes, reads and no-op requests
    for (int i = 0; i < 160; i++) begin
      bit wa, wd;
      wa = (i % 3 != 0);
      wd = (i % 7 == 3) ? 1'b1 : wa;
      step(wa, wd, AW'(32'h4000 + i), DW'(i * 9 + 5), DW'(i * 13 + 1),
           (i % 5 == 4), AW'(32'h8000 + i * 7), i[2] ^ i[0]);
    end
    idle(30);
    chk(ew_h == ew_t, "R6", "every write delivered", ew_h, ew_t);
    chk(er_h == er_t, "R7", "every read released", er_h, er_t);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 20000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule